// File: doc/BRIEF.md
# Write Latency Calibration Sequencer

This block sets the extra coarse delay for each byte lane of a memory write path, so that write data reaches the DRAM on the clock edge at which the write command expects it. Write leveling has already placed each byte's strobe on the nearest clock edge. That stage leaves a starting tap value per byte, and the sequencer takes those values as an input. From that starting point the sequencer can only add delay, in steps of one whole memory clock (four quarter-clock taps). The delay line has sixteen taps, so the sum of the leveling tap and the added taps can never pass 15.

Software or a higher-level calibration engine pulses `start` and names the rank to calibrate. The sequencer then takes each byte lane in turn, lowest first. For each trial it asks an external write/read engine to write a fixed burst and read it back, and it gives the engine the byte and the tap to use. If the returned 64-bit word differs from the golden word, the sequencer adds one clock of delay and tries again. When the word matches, it repeats the trial once to confirm the result, checks the result against the other ranks of the same byte, and stores the added clock count and the final tap for that rank and byte.

A failure stops the run. The sequencer then reports an error code and the failing byte. Before it reports a failure, it checks whether the returned word is the golden burst shifted by whole 16-bit beats. This tells it whether the data arrived early or late.

Top module: `wrlat_cal_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `done`=0, `err`=0, `err_code`=0, `eng_req`=0, and every `tap_out` and `add_out` field is 0.
- R2: After an accepted `start`, bytes are calibrated in ascending order. The first trial of each byte requests that byte's write-leveling tap from `base_tap[4*b+:4]`.
- R3: After a mismatched trial, the next trial of the same byte requests exactly 4 taps more. The added clock count never passes min(3, (15 - base) / 4).
- R4: After a matching trial, the sequencer repeats one trial at the same tap. If that trial also matches, it stores the added clock count in `add_out[2*(r*NB+b)+:2]` and the tap in `tap_out[4*(r*NB+b)+:4]`.
- R5: If the confirming trial does not match, the run fails with `err_code`=5 (confirmation failed).
- R6: Read-back beats are numbered from bit 63 down, and the golden word is 64'hFF00AA5555AA9966. The data is late by k beats (k=1..3) when beats k..3 of the word equal golden beats 0..3-k. If the first trial of a byte is not an exact match and the data is late, the run fails at once with `err_code`=2 and makes no further trial.
- R7: The data is early by k beats when beats 0..3-k of the word equal golden beats k..3. If the added delay is already at its maximum and the last word is early, the run fails with `err_code`=1 (not enough range).
- R8: If the added delay is at its maximum and the last word is neither exact nor early, the run fails with `err_code`=3 (pattern not found).
- R9: Another rank may already hold a stored result for the same byte. If the new added clock count differs from it by more than `SKEW_LIMIT`, the run fails with `err_code`=4 and the new result is not stored.
- R10: At the end of a run `done` goes to 1. `err` is 1 exactly when `err_code` is nonzero, and `err_byte` names the failing byte. These outputs hold until the next `start`, and a `start` that arrives during a run is ignored.
- R11: `eng_req` stays high, with `eng_byte` and `eng_tap` stable, until the cycle in which `eng_ack` is sampled high. `eng_rdata` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a calibration run |
| cal_rank | input | RW (1) | Rank to calibrate, latched at start |
| base_tap | input | 4*NB (16) | Write-leveling tap per byte |
| eng_req | output | 1 | Trial request to the write/read engine |
| eng_byte | output | BW (2) | Byte lane of the trial |
| eng_tap | output | 4 | Coarse tap to apply for the trial |
| eng_ack | input | 1 | Trial complete, read data valid |
| eng_rdata | input | 64 | Read-back word |
| done | output | 1 | Run finished (held) |
| err | output | 1 | Run failed (held) |
| err_code | output | 3 | 0 none, 1 range, 2 late, 3 not found, 4 skew, 5 confirm |
| err_byte | output | BW (2) | Byte lane that failed |
| tap_out | output | 4*NR*NB (32) | Final tap per rank and byte |
| add_out | output | 2*NR*NB (16) | Added clocks per rank and byte |

## Verification
The bench covers these corner cases:
- A byte whose leveling tap leaves no room to add delay. A design that computed the range without the 15-tap ceiling would request a tap that wraps around.
- A byte that first reads back late. A design that went on adding delay here would make extra trials or report the wrong code.
- Data still one beat early at the maximum delay, and a word that never matches at all. A wrong early/late decode would swap codes 1 and 3.
- A confirming trial that fails, and a second rank whose result is too far from the first. A design that skipped the confirmation, or that stored a result despite a skew error, would leave the wrong trial count or the wrong stored outputs.
- A `start` that arrives during a run. A design that accepted it would restart the byte sequence.

// File: rtl/wrlat_pkg.sv
// Shared constants and types for the write latency calibration sequencer.
// Assumes a 64-bit read-back word made of four 16-bit beats, first beat in the MSBs.
package wrlat_pkg;
    localparam int BEAT_W       = 16;
    localparam int WORD_W       = 64;
    localparam int BEATS        = WORD_W / BEAT_W;
    localparam int TAP_W        = 4;
    localparam int TAPS_PER_CLK = 4;
    localparam int MAX_TAP      = 15;
    localparam int MAX_ADD_CLK  = 3;
    localparam int ADD_W        = 2;
    localparam int NIB_W        = 4;

    localparam logic [WORD_W-1:0] GOLDEN = 64'hFF00AA5555AA9966;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_RANGE    = 3'd1,
        ERR_LATE     = 3'd2,
        ERR_NOTFOUND = 3'd3,
        ERR_SKEW     = 3'd4,
        ERR_CONFIRM  = 3'd5
    } err_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_EVAL = 2'd2,
        S_REC  = 2'd3
    } state_e;

    typedef struct packed {
        logic exact;
        logic early;
        logic late;
    } verdict_t;
endpackage

// File: rtl/wrlat_pattern_cmp.sv
// Classifies a read-back word against the golden burst.
// exact: every nibble matches. early: the word is the golden burst moved toward
// the first beat by 1..BEATS-1 whole beats. late: moved toward the last beat.
// Purely combinational; assumes the golden beats are pairwise distinct.
module wrlat_pattern_cmp
    import wrlat_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output verdict_t          verdict
);
    localparam int WORD_NIBS = WORD_W / NIB_W;

    logic [WORD_NIBS-1:0] exact_nm;
    logic [BEATS-1:0]     early_k;
    logic [BEATS-1:0]     late_k;

    // per-nibble equality for the unshifted case
    for (genvar n = 0; n < WORD_NIBS; n++) begin : g_exact
        assign exact_nm[n] = (word[n*NIB_W +: NIB_W] == GOLDEN[n*NIB_W +: NIB_W]);
    end

    assign early_k[0] = 1'b0;
    assign late_k[0]  = 1'b0;

    // per-nibble equality for each whole-beat shift in each direction
    for (genvar k = 1; k < BEATS; k++) begin : g_shift
        localparam int LEN  = (BEATS - k) * BEAT_W;
        localparam int NIBS = LEN / NIB_W;
        logic [NIBS-1:0] e_nm;
        logic [NIBS-1:0] l_nm;
        for (genvar n = 0; n < NIBS; n++) begin : g_nib
            assign e_nm[n] = (word[WORD_W-LEN + n*NIB_W +: NIB_W] == GOLDEN[n*NIB_W +: NIB_W]);
            assign l_nm[n] = (word[n*NIB_W +: NIB_W] == GOLDEN[WORD_W-LEN + n*NIB_W +: NIB_W]);
        end
        assign early_k[k] = &e_nm;
        assign late_k[k]  = &l_nm;
    end

    // fold the per-shift hits into one verdict
    always_comb begin
        verdict.exact = &exact_nm;
        verdict.early = |early_k;
        verdict.late  = |late_k;
    end
endmodule

// File: rtl/wrlat_result_store.sv
// Per rank and byte storage of the calibrated added-clock count and final tap,
// with a valid flag per entry, plus the rank-to-rank skew test for a new result.
// Assumes only ranks other than the one being written take part in the skew test.
module wrlat_result_store
    import wrlat_pkg::*;
#(
    parameter int NB         = 4,
    parameter int NR         = 2,
    parameter int BW         = 2,
    parameter int RW         = 1,
    parameter int SKEW_LIMIT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [RW-1:0]           wr_rank,
    input  logic [BW-1:0]           wr_byte,
    input  logic [ADD_W-1:0]        wr_add,
    input  logic [TAP_W-1:0]        wr_tap,
    output logic                    skew_bad,
    output logic [NR*NB*TAP_W-1:0]  tap_flat,
    output logic [NR*NB*ADD_W-1:0]  add_flat
);
    logic [ADD_W-1:0] add_q [NR][NB];
    logic [TAP_W-1:0] tap_q [NR][NB];
    logic             val_q [NR][NB];

    for (genvar r = 0; r < NR; r++) begin : g_rank
        for (genvar b = 0; b < NB; b++) begin : g_byte
            // hold one entry; overwrite on a recorded result for this rank and byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    add_q[r][b] <= '0;
                    tap_q[r][b] <= '0;
                    val_q[r][b] <= 1'b0;
                end else if (wr_en && wr_rank == RW'(r) && wr_byte == BW'(b)) begin
                    add_q[r][b] <= wr_add;
                    tap_q[r][b] <= wr_tap;
                    val_q[r][b] <= 1'b1;
                end
            end
            assign tap_flat[(r*NB+b)*TAP_W +: TAP_W] = tap_q[r][b];
            assign add_flat[(r*NB+b)*ADD_W +: ADD_W] = add_q[r][b];
        end
    end

    function automatic int abs_diff(input logic [ADD_W-1:0] a, input logic [ADD_W-1:0] b);
        return (a > b) ? int'(a - b) : int'(b - a);
    endfunction

    // flag a new result too far from any other rank's stored result
    always_comb begin
        skew_bad = 1'b0;
        for (int r = 0; r < NR; r++) begin
            if (RW'(r) != wr_rank && val_q[r][wr_byte] &&
                abs_diff(wr_add, add_q[r][wr_byte]) > SKEW_LIMIT)
                skew_bad = 1'b1;
        end
    end
endmodule

// File: rtl/wrlat_ctrl.sv
// Sequencing FSM: walks the bytes in order, issues trials to the write/read
// engine, steps the added delay one clock at a time, confirms a match with a
// repeat trial and records the result or stops with an error code.
// Assumes eng_ack is a single-cycle pulse that only comes while eng_req is high.
module wrlat_ctrl
    import wrlat_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2,
    parameter int RW = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [RW-1:0]         cal_rank,
    input  logic [NB*TAP_W-1:0]   base_tap,
    input  logic                  eng_ack,
    input  logic [WORD_W-1:0]     eng_rdata,
    input  verdict_t              verdict,
    input  logic                  skew_bad,
    output logic [WORD_W-1:0]     word,
    output logic                  eng_req,
    output logic [BW-1:0]         eng_byte,
    output logic [TAP_W-1:0]      eng_tap,
    output logic                  rec_en,
    output logic [RW-1:0]         rec_rank,
    output logic [ADD_W-1:0]      rec_add,
    output logic                  done,
    output logic                  err,
    output err_e                  err_code,
    output logic [BW-1:0]         err_byte
);
    state_e           st_q;
    logic [BW-1:0]    byte_q;
    logic [ADD_W-1:0] add_q;
    logic             confirm_q;
    logic [RW-1:0]    rank_q;
    logic [WORD_W-1:0] word_q;
    logic             done_q, err_q;
    err_e             code_q;
    logic [BW-1:0]    ebyte_q;

    logic [TAP_W-1:0] base_sel, room, cur_tap;
    logic [ADD_W-1:0] max_add;
    logic             last_byte;
    logic             ev_fail;
    err_e             ev_code;

    // tap budget for the current byte: room left above the leveling tap
    always_comb begin
        base_sel  = base_tap[int'(byte_q)*TAP_W +: TAP_W];
        room      = (TAP_W'(MAX_TAP) - base_sel) >> $clog2(TAPS_PER_CLK);
        max_add   = (room > TAP_W'(MAX_ADD_CLK)) ? ADD_W'(MAX_ADD_CLK) : room[ADD_W-1:0];
        cur_tap   = base_sel + {add_q, 2'b00};
        last_byte = (byte_q == BW'(NB-1));
    end

    // decide whether the evaluated trial ends the run with an error
    always_comb begin
        ev_fail = 1'b0;
        ev_code = ERR_NONE;
        if (!verdict.exact) begin
            if (confirm_q) begin
                ev_fail = 1'b1;
                ev_code = ERR_CONFIRM;
            end else if (add_q == '0 && verdict.late) begin
                ev_fail = 1'b1;
                ev_code = ERR_LATE;
            end else if (add_q >= max_add) begin
                ev_fail = 1'b1;
                ev_code = verdict.early ? ERR_RANGE : ERR_NOTFOUND;
            end
        end
    end

    // main sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            byte_q    <= '0;
            add_q     <= '0;
            confirm_q <= 1'b0;
            rank_q    <= '0;
            word_q    <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            code_q    <= ERR_NONE;
            ebyte_q   <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        st_q      <= S_REQ;
                        byte_q    <= '0;
                        add_q     <= '0;
                        confirm_q <= 1'b0;
                        rank_q    <= cal_rank;
                        done_q    <= 1'b0;
                        err_q     <= 1'b0;
                        code_q    <= ERR_NONE;
                        ebyte_q   <= '0;
                    end
                end
                S_REQ: begin
                    if (eng_ack) begin
                        word_q <= eng_rdata;
                        st_q   <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (ev_fail) begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        code_q  <= ev_code;
                        ebyte_q <= byte_q;
                        st_q    <= S_IDLE;
                    end else if (verdict.exact) begin
                        if (confirm_q) begin
                            st_q <= S_REC;
                        end else begin
                            confirm_q <= 1'b1;
                            st_q      <= S_REQ;
                        end
                    end else begin
                        add_q <= add_q + 1'b1;
                        st_q  <= S_REQ;
                    end
                end
                S_REC: begin
                    if (skew_bad) begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        code_q  <= ERR_SKEW;
                        ebyte_q <= byte_q;
                        st_q    <= S_IDLE;
                    end else if (last_byte) begin
                        done_q <= 1'b1;
                        st_q   <= S_IDLE;
                    end else begin
                        byte_q    <= byte_q + 1'b1;
                        add_q     <= '0;
                        confirm_q <= 1'b0;
                        st_q      <= S_REQ;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // drive the engine, the result store and the held status
    always_comb begin
        word     = word_q;
        eng_req  = (st_q == S_REQ);
        eng_byte = byte_q;
        eng_tap  = cur_tap;
        rec_en   = (st_q == S_REC) && !skew_bad;
        rec_rank = rank_q;
        rec_add  = add_q;
        done     = done_q;
        err      = err_q;
        err_code = code_q;
        err_byte = ebyte_q;
    end
endmodule

// File: rtl/wrlat_cal_seq.sv
// Top of the write latency calibration sequencer. Connects the sequencing FSM,
// the read-back pattern classifier and the per rank/byte result store.
// Assumes base_tap is stable for the length of a run.
module wrlat_cal_seq
    import wrlat_pkg::*;
#(
    parameter int NB         = 4,
    parameter int NR         = 2,
    parameter int SKEW_LIMIT = 1,
    localparam int BW        = (NB > 1) ? $clog2(NB) : 1,
    localparam int RW        = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [RW-1:0]            cal_rank,
    input  logic [NB*4-1:0]          base_tap,
    output logic                     eng_req,
    output logic [BW-1:0]            eng_byte,
    output logic [3:0]               eng_tap,
    input  logic                     eng_ack,
    input  logic [63:0]              eng_rdata,
    output logic                     done,
    output logic                     err,
    output logic [2:0]               err_code,
    output logic [BW-1:0]            err_byte,
    output logic [NR*NB*4-1:0]       tap_out,
    output logic [NR*NB*2-1:0]       add_out
);
    verdict_t          verdict;
    logic [WORD_W-1:0] word;
    logic              skew_bad;
    logic              rec_en;
    logic [RW-1:0]     rec_rank;
    logic [ADD_W-1:0]  rec_add;
    err_e              code;

    wrlat_ctrl #(.NB(NB), .BW(BW), .RW(RW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_rank(cal_rank),
        .base_tap(base_tap), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .verdict(verdict), .skew_bad(skew_bad), .word(word),
        .eng_req(eng_req), .eng_byte(eng_byte), .eng_tap(eng_tap),
        .rec_en(rec_en), .rec_rank(rec_rank), .rec_add(rec_add),
        .done(done), .err(err), .err_code(code), .err_byte(err_byte)
    );

    wrlat_pattern_cmp u_cmp (
        .word(word), .verdict(verdict)
    );

    wrlat_result_store #(
        .NB(NB), .NR(NR), .BW(BW), .RW(RW), .SKEW_LIMIT(SKEW_LIMIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(rec_en), .wr_rank(rec_rank),
        .wr_byte(eng_byte), .wr_add(rec_add), .wr_tap(eng_tap),
        .skew_bad(skew_bad), .tap_flat(tap_out), .add_flat(add_out)
    );

    assign err_code = code;
endmodule

// File: rtl/wrlat_cal_sva.sv
// Port-level checker for wrlat_cal_seq, attached by bind below.
module wrlat_cal_sva #(
    parameter int NB = 4,
    parameter int NR = 2,
    parameter int BW = 2,
    parameter int RW = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [RW-1:0]      cal_rank,
    input logic [NB*4-1:0]    base_tap,
    input logic               eng_req,
    input logic [BW-1:0]      eng_byte,
    input logic [3:0]         eng_tap,
    input logic               eng_ack,
    input logic [63:0]        eng_rdata,
    input logic               done,
    input logic               err,
    input logic [2:0]         err_code,
    input logic [BW-1:0]      err_byte,
    input logic [NR*NB*4-1:0] tap_out,
    input logic [NR*NB*2-1:0] add_out
);
    logic [3:0] base_sel;
    logic [3:0] delta;
    logic       was_rst;

    assign base_sel = base_tap[int'(eng_byte)*4 +: 4];
    assign delta    = eng_tap - base_sel;

    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: state after a reset edge
    always @(negedge clk) begin
        if (was_rst)
            assert_reset_state_R1: assert (!done && !err && !eng_req && err_code == 3'd0
                                           && tap_out == '0 && add_out == '0);
    end

    assert_tap_on_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (eng_tap >= base_sel) && (delta[1:0] == 2'b00) && (delta[3:2] <= 2'd3));

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_ack |=> eng_req && $stable(eng_tap) && $stable(eng_byte));

    assert_status_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(err) && $stable(err_code) && $stable(err_byte));

    assert_no_req_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !eng_req);

    assert_err_matches_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (err_code != 3'd0)));

    assert_results_still_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> $stable(tap_out) && $stable(add_out));
endmodule

bind wrlat_cal_seq wrlat_cal_sva #(.NB(NB), .NR(NR), .BW(BW), .RW(RW)) u_sva (.*);

// File: tb/sim_wrlat_cal_seq.sv
// Behavioural reference bench: a queue of expected trials, a modelled engine
// and stored-result arrays, compared against the design each clock.
module sim_wrlat_cal_seq;
    localparam int NB = 4, NR = 2, BW = 2, RW = 1, LAT = 2, JUNK_E = 99;
    localparam logic [63:0] GOOD = 64'hFF00AA5555AA9966;
    localparam logic [63:0] JUNK = 64'h0123456789ABCDEF;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, eng_ack = 1'b0;
    logic [RW-1:0] cal_rank = '0;
    logic [NB*4-1:0] base_tap = '0;
    logic [63:0] eng_rdata = '0;
    logic eng_req, done, err;
    logic [BW-1:0] eng_byte, err_byte;
    logic [3:0] eng_tap;
    logic [2:0] err_code;
    logic [NR*NB*4-1:0] tap_out;
    logic [NR*NB*2-1:0] add_out;

    always #4ns clk = ~clk;

    wrlat_cal_seq #(.NB(NB), .NR(NR), .SKEW_LIMIT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_rank(cal_rank), .base_tap(base_tap),
        .eng_req(eng_req), .eng_byte(eng_byte), .eng_tap(eng_tap), .eng_ack(eng_ack),
        .eng_rdata(eng_rdata), .done(done), .err(err), .err_code(err_code),
        .err_byte(err_byte), .tap_out(tap_out), .add_out(add_out)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct { int b; int tap; logic [63:0] rd; string tag; } ent_t;
    ent_t q[$];
    int base[NB], need[NB];
    bit flaky[NB];
    int st_add[NR][NB], st_tap[NR][NB];
    bit st_val[NR][NB];

    function automatic logic [63:0] word_for(input int e);
        logic [63:0] w;
        if (e >= JUNK_E) return JUNK;
        for (int i = 0; i < 4; i++) begin
            int src = i + e;
            w[63-16*i -: 16] = (src >= 0 && src < 4) ? GOOD[63-16*src -: 16] : 16'hFFFF;
        end
        return w;
    endfunction

    // reference model: expected trial list and outcome of one run
    task automatic plan(input int rank, output int code, output int eb);
        code = 0; eb = 0;
        for (int b = 0; b < NB; b++) begin
            int add = 0;
            int maxa = (15 - base[b]) / 4;
            if (maxa > 3) maxa = 3;
            forever begin
                int tap = base[b] + 4 * add;
                int e = (need[b] == JUNK_E) ? JUNK_E : need[b] - add;
                q.push_back('{b, tap, word_for(e), (add == 0) ? "R2 first trial" : "R3 retry trial"});
                if (e == 0) begin
                    if (flaky[b]) begin
                        q.push_back('{b, tap, JUNK, "R4 confirm trial"});
                        code = 5; eb = b; return;
                    end
                    q.push_back('{b, tap, GOOD, "R4 confirm trial"});
                    for (int r = 0; r < NR; r++)
                        if (r != rank && st_val[r][b] && (add - st_add[r][b] > 1 || st_add[r][b] - add > 1)) begin
                            code = 4; eb = b; return;
                        end
                    st_add[rank][b] = add; st_tap[rank][b] = tap; st_val[rank][b] = 1;
                    break;
                end else if (e != JUNK_E && e < 0 && add == 0) begin
                    code = 2; eb = b; return;
                end else if (add < maxa) begin
                    add++;
                end else begin
                    code = (e != JUNK_E && e > 0 && e < 4) ? 1 : 3; eb = b; return;
                end
            end
        end
    endtask

    // modelled write/read engine, compared against the expected trial queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && eng_req) begin
                ent_t t;
                if (q.size() == 0) begin
                    chk(0, "R2 unexpected trial", {60'd0, eng_tap}, 64'd0);
                    t = '{0, 0, JUNK, "none"};
                end else begin
                    t = q.pop_front();
                    chk(eng_byte == BW'(t.b), {t.tag, " byte"}, 64'(eng_byte), 64'(t.b));
                    chk(eng_tap == 4'(t.tap), {t.tag, " tap"}, 64'(eng_tap), 64'(t.tap));
                end
                repeat (LAT) begin
                    @(negedge clk);
                    chk(eng_req && eng_tap == 4'(t.tap), "R11 request held", 64'(eng_tap), 64'(t.tap));
                end
                eng_ack = 1'b1; eng_rdata = t.rd;
                @(negedge clk);
                eng_ack = 1'b0;
            end
        end
    end

    task automatic run(input int rank, input string tag, input bit poke);
        int code, eb;
        bit ok = 1;
        plan(rank, code, eb);
        for (int b = 0; b < NB; b++) base_tap[4*b +: 4] = 4'(base[b]);
        cal_rank = RW'(rank);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            cal_rank = RW'(1 - rank); start = 1'b1;
            @(negedge clk) start = 1'b0; cal_rank = RW'(rank);
        end
        while (!done) @(negedge clk);
        chk(err == (code != 0), {tag, " err flag"}, 64'(err), 64'(code != 0));
        chk(err_code == 3'(code), {tag, " code"}, 64'(err_code), 64'(code));
        if (code != 0) chk(err_byte == BW'(eb), {tag, " failing byte"}, 64'(err_byte), 64'(eb));
        chk(q.size() == 0, {tag, " trial count"}, 64'(q.size()), 64'd0);
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++)
                if (tap_out[(r*NB+b)*4 +: 4] != 4'(st_tap[r][b]) ||
                    add_out[(r*NB+b)*2 +: 2] != 2'(st_add[r][b])) ok = 0;
        chk(ok, {tag, " R4 stored results"}, {32'd0, tap_out}, 64'd0);
        repeat (12) @(negedge clk);
        chk(done && err_code == 3'(code), {tag, " R10 status held"}, 64'(err_code), 64'(code));
        q.delete();
    endtask

    initial begin
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) begin st_add[r][b] = 0; st_tap[r][b] = 0; st_val[r][b] = 0; end
        repeat (3) @(negedge clk);
        chk(!done && !err && err_code == 0 && !eng_req, "R1 reset status", {61'd0, err_code}, 64'd0);
        chk(tap_out == '0 && add_out == '0, "R1 reset results", {32'd0, tap_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        base = '{0, 1, 2, 3}; flaky = '{0, 0, 0, 0};
        need = '{0, 2, 1, 3};      run(0, "R2 R10 rank0 all pass, busy start ignored", 1);
        need = '{1, 2, 1, 3};      run(1, "R4 rank1 all pass", 0);
        need = '{3, 2, 1, 3};      run(1, "R9 skew", 0);
        base = '{13, 1, 2, 3};
        need = '{1, 0, 0, 0};      run(0, "R7 no room", 0);
        base = '{0, 1, 2, 3};
        need = '{-1, 0, 0, 0};     run(0, "R6 late", 0);
        need = '{0, JUNK_E, 0, 0}; run(0, "R8 not found", 0);
        need = '{0, 2, 1, 3}; flaky = '{0, 0, 1, 0};
                                   run(0, "R5 confirm fails", 0);
        flaky = '{0, 0, 0, 0};
        need = '{4, 0, 0, 0};      run(0, "R7 early at max", 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R10 done not reached actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule